// File: doc/BRIEF.md
# Pin Event GPIO Controller

This block is a 32-pin general-purpose I/O controller on a plain register bus of 32-bit word accesses. Software picks each pin's direction, can switch an output pin to open-drain behaviour, and writes the output value. Reads of the data word mix the stored output value (for output pins) with the synchronised pad level (for input pins). Every pin level passes through a two-stage synchroniser before any logic sees it.

Edges on the synchronised levels are caught in a sticky event word, whatever the pin's direction. A mask word selects which events drive the single combined interrupt line. Software clears events by writing ones to them. A build option picks how edge sensitivity is coded for each pin: one bit per pin (falling only or both edges), or two bits per pin spread over two words, which also allows rising only. A second build option makes the four highest-numbered pins input only.

Register word byte offsets: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, edge word A 0x14, edge word B 0x18. Pin n always sits at bit 31-n, so pin 0 is the most significant bit.

Top module: `pin_event_gpio`

## Requirements
- R1: After reset every register reads 0, `pinOe` is 0 and `irq` is low.
- R2: A direction bit of 1 makes the pin an output, and `pinOe` for that pin follows the bit on the cycle after the write. A pin whose direction bit is 0 never has its `pinOe` bit set.
- R3: Pin n is bit 31-n in every register and in `pinIn`, `pinOut` and `pinOe`. Pin 0 is bit 31.
- R4: On an output pin with its open-drain bit set, a data value of 0 drives low (`pinOe` 1, `pinOut` 0) and a data value of 1 releases the pad (`pinOe` 0).
- R5: Reading the data word (0x08) returns the stored data bit for output pins and the synchronised pad level for input pins. A pad change shows up in the readback two clock edges after it reaches `pinIn`.
- R6: With the one-bit coding, an edge word A bit of 1 captures only falling edges, and a bit of 0 captures both rising and falling edges. The event bit is set on the third clock edge after the pad change.
- R7: Writing the event word (0x0C) clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R8: `irq` is high exactly when the event word AND the mask word (0x10, 1 = enabled) is nonzero.
- R9: If an edge is captured on the same clock edge as a write that clears that event bit, the bit stays set.
- R10: When the input-only option is on, direction bits for pins 28 to 31 (bits 3..0) read 0, writes to them are ignored, and those pins never drive.
- R11: With the two-bit coding, pins 0 to 15 use edge word A (0x14) and pins 16 to 31 use edge word B (0x18). Each pin has a field at bit (15 - (n mod 16)) * 2, coded 00 both edges, 01 rising only, 10 falling only. With the one-bit coding, edge word B reads 0 and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 32 | Pad levels, pin n at bit 31-n |
| pinOut | output | 32 | Output value for each pad |
| pinOe | output | 32 | Output enable for each pad |
| busSel | input | 1 | Register access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of a read access, 0 otherwise |
| irq | output | 1 | Combined interrupt request |

## Verification
Edge capture is driven with rising-only and falling-only pad steps on pins set to both-edge mode and on pins set to falling-only mode. This separates the two one-bit codings from each other and from a detector that ignores polarity. A two-bit build sees a rising step and a falling step on one pin from each half of the pin range, which shows whether each pin reads the correct word and field position. Data readback is tried with a pad driven opposite to an output's stored value, which exposes any readback that comes from the pad. A clearing write is timed to land on the same edge as a fresh capture, to check that the capture wins.

// File: rtl/pin_event_gpio_pkg.sv
package pin_event_gpio_pkg;

  localparam int PINS      = 32;
  localparam int HALF_PINS = PINS / 2;
  localparam int LOCKED    = 4;   // number of highest pins made input-only

  localparam logic [7:0] OFS_DIR = 8'h00;
  localparam logic [7:0] OFS_ODR = 8'h04;
  localparam logic [7:0] OFS_DAT = 8'h08;
  localparam logic [7:0] OFS_EVT = 8'h0C;
  localparam logic [7:0] OFS_MSK = 8'h10;
  localparam logic [7:0] OFS_ECA = 8'h14;
  localparam logic [7:0] OFS_ECB = 8'h18;

  // write strobes from the decoder to the register datapath
  typedef struct packed {
    logic dir;
    logic odr;
    logic dat;
    logic evt;
    logic msk;
    logic ecA;
    logic ecB;
  } gpioWr_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DIR,
    RD_ODR,
    RD_DAT,
    RD_EVT,
    RD_MSK,
    RD_ECA,
    RD_ECB
  } gpioRd_e;

endpackage

// File: rtl/pin_event_gpio_sync.sv
module pin_event_gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] stageOne;
  logic [W-1:0] stageTwo;
  logic [W-1:0] prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageOne  <= '0;
      stageTwo  <= '0;
      prevLevel <= '0;
    end else begin
      stageOne  <= pinIn;
      stageTwo  <= stageOne;
      prevLevel <= stageTwo;
    end
  end

  assign level = stageTwo;
  assign rise  = stageTwo & ~prevLevel;
  assign fall  = ~stageTwo & prevLevel;

endmodule

// File: rtl/pin_event_gpio_decode.sv
module pin_event_gpio_decode
  import pin_event_gpio_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter bit HAS_ECB = 1'b0
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output gpioWr_t           wrStb,
  output gpioRd_e           rdSel
);

  gpioRd_e hitReg;

  always_comb begin
    hitReg = RD_NONE;
    if (busAddr == ADDR_W'(OFS_DIR))      hitReg = RD_DIR;
    else if (busAddr == ADDR_W'(OFS_ODR)) hitReg = RD_ODR;
    else if (busAddr == ADDR_W'(OFS_DAT)) hitReg = RD_DAT;
    else if (busAddr == ADDR_W'(OFS_EVT)) hitReg = RD_EVT;
    else if (busAddr == ADDR_W'(OFS_MSK)) hitReg = RD_MSK;
    else if (busAddr == ADDR_W'(OFS_ECA)) hitReg = RD_ECA;
    else if (HAS_ECB && busAddr == ADDR_W'(OFS_ECB)) hitReg = RD_ECB;
  end

  always_comb begin
    wrStb = '0;
    if (busSel && busWrite) begin
      wrStb.dir = (hitReg == RD_DIR);
      wrStb.odr = (hitReg == RD_ODR);
      wrStb.dat = (hitReg == RD_DAT);
      wrStb.evt = (hitReg == RD_EVT);
      wrStb.msk = (hitReg == RD_MSK);
      wrStb.ecA = (hitReg == RD_ECA);
      wrStb.ecB = (hitReg == RD_ECB);
    end
  end

  assign rdSel = (busSel && !busWrite) ? hitReg : RD_NONE;

endmodule

// File: rtl/pin_event_gpio_regs.sv
module pin_event_gpio_regs
  import pin_event_gpio_pkg::*;
#(
  parameter bit TWO_BIT_MODE   = 1'b0,
  parameter bit INPUT_ONLY_TOP = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  gpioWr_t         wrStb,
  input  gpioRd_e         rdSel,
  input  logic [PINS-1:0] busWdata,
  input  logic [PINS-1:0] pinLevel,
  input  logic [PINS-1:0] pinRise,
  input  logic [PINS-1:0] pinFall,
  output logic [PINS-1:0] busRdata,
  output logic [PINS-1:0] pinOut,
  output logic [PINS-1:0] pinOe,
  output logic            irq
);

  localparam logic [PINS-1:0] DIR_WMASK =
    INPUT_ONLY_TOP ? {{(PINS-LOCKED){1'b1}}, {LOCKED{1'b0}}} : {PINS{1'b1}};

  logic [PINS-1:0] dirQ, odrQ, datQ, evtQ, mskQ, ecAQ;
  logic [PINS-1:0] ecBView;
  logic [PINS-1:0] clrVec;
  logic [PINS-1:0] capVec;
  logic [PINS-1:0] dataView;

  assign clrVec = wrStb.evt ? busWdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
      odrQ <= '0;
      datQ <= '0;
      evtQ <= '0;
      mskQ <= '0;
      ecAQ <= '0;
    end else begin
      if (wrStb.dir) dirQ <= busWdata & DIR_WMASK;
      if (wrStb.odr) odrQ <= busWdata;
      if (wrStb.dat) datQ <= busWdata;
      if (wrStb.msk) mskQ <= busWdata;
      if (wrStb.ecA) ecAQ <= busWdata;
      evtQ <= (evtQ & ~clrVec) | capVec;
    end
  end

  // second edge word exists only with the two-bit coding
  generate
    if (TWO_BIT_MODE) begin : g_ecb
      logic [PINS-1:0] ecBQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          ecBQ <= '0;
        else if (wrStb.ecB) ecBQ <= busWdata;
      end
      assign ecBView = ecBQ;
    end else begin : g_no_ecb
      logic unusedEcbStrobe;
      assign unusedEcbStrobe = wrStb.ecB;
      assign ecBView = '0;
    end
  endgenerate

  // per-pin edge selection; pin n lives at bit PINS-1-n
  generate
    for (genvar n = 0; n < PINS; n++) begin : g_pin
      localparam int B = PINS - 1 - n;
      if (TWO_BIT_MODE) begin : g_two
        logic [1:0] fld;
        if (n < HALF_PINS) begin : g_lo
          assign fld = ecAQ[(HALF_PINS - 1 - n) * 2 +: 2];
        end else begin : g_hi
          assign fld = ecBView[(HALF_PINS - 1 - (n - HALF_PINS)) * 2 +: 2];
        end
        assign capVec[B] = (fld == 2'b00) ? (pinRise[B] | pinFall[B]) :
                           (fld == 2'b01) ? pinRise[B] :
                           (fld == 2'b10) ? pinFall[B] : 1'b0;
      end else begin : g_one
        assign capVec[B] = ecAQ[B] ? pinFall[B] : (pinRise[B] | pinFall[B]);
      end
    end
  endgenerate

  assign dataView = (datQ & dirQ) | (pinLevel & ~dirQ);

  always_comb begin
    unique case (rdSel)
      RD_DIR:  busRdata = dirQ;
      RD_ODR:  busRdata = odrQ;
      RD_DAT:  busRdata = dataView;
      RD_EVT:  busRdata = evtQ;
      RD_MSK:  busRdata = mskQ;
      RD_ECA:  busRdata = ecAQ;
      RD_ECB:  busRdata = ecBView;
      default: busRdata = '0;
    endcase
  end

  assign pinOut = datQ;
  assign pinOe  = dirQ & ~(odrQ & datQ);
  assign irq    = |(evtQ & mskQ);

  // R2: a direction write takes effect on the following cycle
  p_dir_follows_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.dir |=> (dirQ == ($past(busWdata) & DIR_WMASK)));

  // R2: an input pin never drives
  p_oe_needs_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & ~dirQ) == '0));

  // R10: locked pins never drive
  p_locked_pins_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & ~DIR_WMASK) == '0));

  // R7: an event bit only falls when a one was written to it
  p_clear_needs_w1c_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(evtQ) & ~evtQ) & ~$past(clrVec)) == '0));

  // R9: a captured edge is always held, even against a clear
  p_capture_sticks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|capVec) |=> ((evtQ & $past(capVec)) == $past(capVec)));

endmodule

// File: rtl/pin_event_gpio.sv
module pin_event_gpio
  import pin_event_gpio_pkg::*;
#(
  parameter int ADDR_W         = 5,
  parameter bit TWO_BIT_MODE   = 1'b0,
  parameter bit INPUT_ONLY_TOP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PINS-1:0]   busWdata,
  output logic [PINS-1:0]   busRdata,
  output logic              irq
);

  gpioWr_t         wrStb;
  gpioRd_e         rdSel;
  logic [PINS-1:0] pinLevel, pinRise, pinFall;

  pin_event_gpio_sync #(.W(PINS)) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .pinIn (pinIn),
    .level (pinLevel),
    .rise  (pinRise),
    .fall  (pinFall)
  );

  pin_event_gpio_decode #(.ADDR_W(ADDR_W), .HAS_ECB(TWO_BIT_MODE)) u_decode (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .wrStb    (wrStb),
    .rdSel    (rdSel)
  );

  pin_event_gpio_regs #(
    .TWO_BIT_MODE   (TWO_BIT_MODE),
    .INPUT_ONLY_TOP (INPUT_ONLY_TOP)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .rdSel    (rdSel),
    .busWdata (busWdata),
    .pinLevel (pinLevel),
    .pinRise  (pinRise),
    .pinFall  (pinFall),
    .busRdata (busRdata),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irq      (irq)
  );

endmodule

// File: tb/pin_event_gpio_tb.sv
module pin_event_gpio_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinIn = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdA, rdB, pinOutA, pinOeA, pinOutB, pinOeB;
  logic        irqA, irqB;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  bit          selQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  // one-bit coding, top pins input-only
  pin_event_gpio #(.ADDR_W(5), .TWO_BIT_MODE(1'b0), .INPUT_ONLY_TOP(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinOut(pinOutA), .pinOe(pinOeA),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rdA), .irq(irqA));

  // two-bit coding, no locked pins
  pin_event_gpio #(.ADDR_W(5), .TWO_BIT_MODE(1'b1), .INPUT_ONLY_TOP(1'b0)) u_dut2 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinOut(pinOutB), .pinOe(pinOeB),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rdB), .irq(irqB));

  task automatic doCheck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr32(input logic [4:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  // driver: pushes the expected read value, the monitor compares it
  task automatic rd32(input logic [4:0] a, input bit useB, input logic [31:0] exp, input string tag);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    expQ.push_back(exp); selQ.push_back(useB); tagQ.push_back(tag);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  // monitor: samples read data a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (busSel && !busWrite && expQ.size() > 0) begin
        logic [31:0] e;
        bit s;
        string t;
        e = expQ.pop_front(); s = selQ.pop_front(); t = tagQ.pop_front();
        doCheck(t, s ? rdB : rdA, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R1: reset state
    rd32(5'h00, 0, 32'h0, "R1 dir");
    rd32(5'h04, 0, 32'h0, "R1 odr");
    rd32(5'h08, 0, 32'h0, "R1 dat");
    rd32(5'h0C, 0, 32'h0, "R1 evt");
    rd32(5'h10, 0, 32'h0, "R1 msk");
    rd32(5'h14, 0, 32'h0, "R1 ecA");
    rd32(5'h18, 1, 32'h0, "R1 ecB");
    doCheck("R1 irq", {31'b0, irqA}, 32'h0);
    doCheck("R1 pinOe", pinOeA, 32'h0);

    // R2 / R3: pins 0 and 7 as outputs (bits 31 and 24)
    wr32(5'h00, 32'h8100_0000);
    wr32(5'h08, 32'h8100_0000);
    doCheck("R2 pinOe follows dir", pinOeA, 32'h8100_0000);
    doCheck("R3 pin0 at msb", pinOutA & 32'h8100_0000, 32'h8100_0000);
    rd32(5'h00, 0, 32'h8100_0000, "R2 dir readback");

    // R10: locked top pins
    wr32(5'h00, 32'hFFFF_FFFF);
    rd32(5'h00, 0, 32'hFFFF_FFF0, "R10 dir locked bits");
    doCheck("R10 locked pins not driven", pinOeA & 32'hF, 32'h0);
    rd32(5'h00, 1, 32'hFFFF_FFFF, "R10 unlocked build");
    wr32(5'h00, 32'h8100_0000);

    // R4: open-drain on pin 0
    wr32(5'h04, 32'h8000_0000);
    doCheck("R4 od data1 releases", pinOeA, 32'h0100_0000);
    wr32(5'h08, 32'h0000_0000);
    doCheck("R4 od data0 drives", pinOeA, 32'h8100_0000);
    doCheck("R4 od data0 low", pinOutA & 32'h8000_0000, 32'h0);

    // R5: data readback
    wr32(5'h08, 32'h0100_0000);
    rd32(5'h08, 0, 32'h0100_0000, "R5 readback pads low");
    pinIn = 32'h8020_0000;          // pin 0 pad high against stored 0, pin 10 input high
    waitCyc(2);
    rd32(5'h08, 0, 32'h0120_0000, "R5 readback mixed");
    waitCyc(3);
    wr32(5'h0C, 32'hFFFF_FFFF);
    rd32(5'h0C, 0, 32'h0, "R7 clear all");

    // R6 / R8: both-edge mode on pin 2 (bit 29)
    pinIn = pinIn | 32'h2000_0000;
    waitCyc(3);
    rd32(5'h0C, 0, 32'h2000_0000, "R6 both mode rising");
    doCheck("R8 irq masked", {31'b0, irqA}, 32'h0);
    wr32(5'h10, 32'h2000_0000);
    doCheck("R8 irq unmasked", {31'b0, irqA}, 32'h1);
    wr32(5'h0C, 32'h0);
    rd32(5'h0C, 0, 32'h2000_0000, "R7 write zero keeps");
    doCheck("R8 irq held", {31'b0, irqA}, 32'h1);
    pinIn = pinIn & ~32'h2000_0000;
    waitCyc(3);
    wr32(5'h0C, 32'h2000_0000);
    rd32(5'h0C, 0, 32'h0, "R7 write one clears");
    doCheck("R8 irq drops", {31'b0, irqA}, 32'h0);
    pinIn = pinIn | 32'h2000_0000;
    waitCyc(3);
    wr32(5'h0C, 32'h2000_0000);
    pinIn = pinIn & ~32'h2000_0000;
    waitCyc(3);
    rd32(5'h0C, 0, 32'h2000_0000, "R6 both mode falling");
    wr32(5'h0C, 32'h2000_0000);

    // R6: falling-only on pin 3 (bit 28)
    wr32(5'h14, 32'h1000_0000);
    pinIn = pinIn | 32'h1000_0000;
    waitCyc(3);
    rd32(5'h0C, 0, 32'h0, "R6 fall-only ignores rising");
    pinIn = pinIn & ~32'h1000_0000;
    waitCyc(3);
    rd32(5'h0C, 0, 32'h1000_0000, "R6 fall-only captures falling");
    wr32(5'h0C, 32'hFFFF_FFFF);

    // R9: clear lands on the same edge as a capture
    pinIn = pinIn | 32'h2000_0000;
    waitCyc(3);
    pinIn = pinIn & ~32'h2000_0000;
    waitCyc(2);
    wr32(5'h0C, 32'h2000_0000);
    rd32(5'h0C, 0, 32'h2000_0000, "R9 capture beats clear");
    doCheck("R9 irq kept", {31'b0, irqA}, 32'h1);
    wr32(5'h0C, 32'h2000_0000);
    rd32(5'h0C, 0, 32'h0, "R9 later clear works");

    // R11: two-bit coding
    wr32(5'h14, 32'h1000_0000);     // pin 1 rising only
    wr32(5'h18, 32'h0080_0000);     // pin 20 falling only
    rd32(5'h18, 1, 32'h0080_0000, "R11 word B stored");
    rd32(5'h18, 0, 32'h0, "R11 one-bit build ignores word B");
    wr32(5'h0C, 32'hFFFF_FFFF);
    pinIn = pinIn | 32'h4000_0800;
    waitCyc(3);
    rd32(5'h0C, 1, 32'h4000_0000, "R11 rising on pin1 only");
    wr32(5'h0C, 32'hFFFF_FFFF);
    pinIn = pinIn & ~32'h4000_0800;
    waitCyc(3);
    rd32(5'h0C, 1, 32'h0000_0800, "R11 falling on pin20 only");

    waitCyc(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule